// File: doc/BRIEF.md
# Streaming Byte-Align Unit

This unit returns a 32-bit word taken from an eight-byte window at a byte offset of 0 to 3. The high half of the window is an operand of the current operation. The low half is a temporary register that holds an operand captured by the previous valid operation. Because that register is loaded on every valid operation, a run of back-to-back align operations can walk through a buffer of several words and produce one realigned word per cycle.

The offset comes from the low bits of a byte-index control register. A write to that register reaches the align datapath only after a fixed write-to-use delay, and a readback returns its value one cycle after the value changes. Each operation carries its own endian flag, and the flag selects how the offset maps onto a right-shift amount. The result is registered and is marked by a one-cycle valid strobe.

Top module: `bytealign_unit`

## Requirements
- R1: After reset, `res_o`, `res_valid_o`, `idx_rdata_o`, the temporary register and the byte-index register are all zero, so a first little-endian align at offset 0 returns 0.
- R2: The window is {current, temp}, with current in bits 63:32. With `src_sel_i`=0 the current half is `op_b_i` and temp captures `op_a_i`. With `src_sel_i`=1 the current half is `op_a_i` and temp captures `op_b_i`.
- R3: With `big_endian_i`=0, align values 0, 1, 2 and 3 give the window shifted right by 0, 8, 16 and 24 bits. The result is the low 32 bits.
- R4: With `big_endian_i`=1, align values 0, 1, 2 and 3 give right shifts of 32, 24, 16 and 8 bits. At value 0 the result is the current operand.
- R5: The temporary register loads on every cycle with `valid_i`=1, whether or not `align_i` is set. It holds while `valid_i`=0.
- R6: A byte-index write sampled at clock edge k first affects an align sampled at edge k+3. Aligns at edges k+1 and k+2 use the old value.
- R7: `idx_rdata_o` returns the full byte-index register one cycle late. After a write at edge k, it shows the new value after edge k+1 and the old value between edges k and k+1.
- R8: An align sampled at an edge updates `res_o` and pulses `res_valid_o` high after that edge. In every other cycle `res_valid_o` is 0 and `res_o` holds its value.
- R9: Only bits [1:0] of the byte-index register set the align value. The upper bits are stored and read back but do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation valid; loads the temporary register |
| align_i | input | 1 | Operation is a byte-align |
| src_sel_i | input | 1 | 0: temp captures A, current is B; 1: temp captures B, current is A |
| big_endian_i | input | 1 | Endian mode of this operation |
| op_a_i | input | 32 | A operand |
| op_b_i | input | 32 | B operand |
| idx_wr_i | input | 1 | Byte-index register write strobe |
| idx_wdata_i | input | 8 | Byte-index write data |
| idx_rdata_o | output | 8 | Byte-index readback, one cycle late |
| res_o | output | 32 | Registered aligned result |
| res_valid_o | output | 1 | Result updated this cycle |

## Verification
Some properties are checked on every cycle. These are the result strobe and the result holding between aligns, the temporary register holding while idle, the two offset-0 identities for each endian mode, and the two-cycle lag from a write to its readback. The bench scenarios cover the rest. These are every non-zero shift in both modes, both operand-select directions, ignored upper index bits, the exact cycle at which a new offset becomes effective, and a non-align operation loading the temporary register.

// File: rtl/bytealign_pkg.sv
package bytealign_pkg;
  typedef enum logic {
    END_LITTLE = 1'b0,
    END_BIG    = 1'b1
  } endian_e;
endpackage

// File: rtl/bytealign_idx_reg.sv
module bytealign_idx_reg #(
  parameter int IDX_W  = 8,
  parameter int AL_W   = 2,
  parameter int WR_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_data_i,
  output logic [IDX_W-1:0] rd_data_o,
  output logic [AL_W-1:0]  eff_o
);
  logic [IDX_W-1:0] idx_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      rd_q  <= '0;
    end else begin
      if (wr_en_i) idx_q <= wr_data_i;
      rd_q <= idx_q;
    end
  end

  assign rd_data_o = rd_q;

  // only the align bits travel down the delay chain
  if (WR_LAT <= 1) begin : g_nodly
    assign eff_o = idx_q[AL_W-1:0];
  end else begin : g_dly
    logic [WR_LAT-2:0][AL_W-1:0] dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dly_q <= '0;
      end else begin
        dly_q[0] <= idx_q[AL_W-1:0];
        for (int i = 1; i < WR_LAT - 1; i++) dly_q[i] <= dly_q[i-1];
      end
    end
    assign eff_o = dly_q[WR_LAT-2];
  end
endmodule

// File: rtl/bytealign_shifter.sv
module bytealign_shifter
  import bytealign_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AL_W   = 2
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] tmp_i,
  input  logic [AL_W-1:0]   align_i,
  input  endian_e           mode_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = AL_W + 1;

  logic [2*DATA_W-1:0] win;
  logic [OFF_W-1:0]    off;

  assign win = {cur_i, tmp_i};
  // byte offset of the result's lowest lane within the window
  assign off = (mode_i == END_BIG) ? OFF_W'(NB) - OFF_W'(align_i) : OFF_W'(align_i);

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [OFF_W:0] src;
    assign src = (OFF_W+1)'(off) + (OFF_W+1)'(j);
    assign res_o[8*j +: 8] = win[8*src +: 8];
  end
endmodule

// File: rtl/bytealign_unit.sv
module bytealign_unit
  import bytealign_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int WR_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              align_i,
  input  logic              src_sel_i,
  input  logic              big_endian_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              idx_wr_i,
  input  logic [IDX_W-1:0]  idx_wdata_i,
  output logic [IDX_W-1:0]  idx_rdata_o,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o
);
  localparam int NB   = DATA_W / 8;
  localparam int AL_W = $clog2(NB);

  logic [DATA_W-1:0] cur_op, cap_op, temp_q, aligned, res_q;
  logic [AL_W-1:0]   idx_eff;
  logic              res_valid_q;
  endian_e           mode;

  assign cur_op = src_sel_i ? op_a_i : op_b_i;
  assign cap_op = src_sel_i ? op_b_i : op_a_i;
  assign mode   = endian_e'(big_endian_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      temp_q <= '0;
    else if (valid_i) temp_q <= cap_op;
  end

  bytealign_idx_reg #(
    .IDX_W (IDX_W),
    .AL_W  (AL_W),
    .WR_LAT(WR_LAT)
  ) u_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (idx_wr_i),
    .wr_data_i(idx_wdata_i),
    .rd_data_o(idx_rdata_o),
    .eff_o    (idx_eff)
  );

  bytealign_shifter #(
    .DATA_W(DATA_W),
    .AL_W  (AL_W)
  ) u_shf (
    .cur_i  (cur_op),
    .tmp_i  (temp_q),
    .align_i(idx_eff),
    .mode_i (mode),
    .res_o  (aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= valid_i & align_i;
      if (valid_i && align_i) res_q <= aligned;
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = res_valid_q;
endmodule

// File: rtl/bytealign_unit_chk.sv
module bytealign_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int AL_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              align_i,
  input logic              src_sel_i,
  input logic              big_endian_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              idx_wr_i,
  input logic [IDX_W-1:0]  idx_wdata_i,
  input logic [IDX_W-1:0]  idx_rdata_o,
  input logic [DATA_W-1:0] res_o,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] temp_q,
  input logic [AL_W-1:0]   idx_eff
);
  p_res_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_i) |=> res_valid_o);

  p_res_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && align_i) |=> (!res_valid_o && $stable(res_o)));

  p_temp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(temp_q));

  p_le_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_i && !big_endian_i && idx_eff == '0) |=> res_o == $past(temp_q));

  p_be_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_i && big_endian_i && idx_eff == '0)
      |=> res_o == ($past(src_sel_i) ? $past(op_a_i) : $past(op_b_i)));

  p_rd_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> ##1 idx_rdata_o == $past(idx_wdata_i, 2));
endmodule

bind bytealign_unit bytealign_unit_chk #(
  .DATA_W(DATA_W),
  .IDX_W (IDX_W),
  .AL_W  (AL_W)
) u_chk (.*);

// File: tb/bytealign_unit_test.sv
module bytealign_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct packed {
    logic [7:0]  idx;
    logic        be;
    logic        sel;
    logic [31:0] ap, bp, a, b, exp;
  } vec_t;

  // rows 0-7: temp=33221100 (from A), current B=77665544
  // rows 8-10: temp=DDCCBBAA (from B), current A=0F0E0D0C; upper idx bits set (R9)
  localparam vec_t VECS [11] = '{
    '{8'h00, 1'b0, 1'b0, 32'h33221100, 32'hAAAAAAAA, 32'h12345678, 32'h77665544, 32'h33221100},
    '{8'h01, 1'b0, 1'b0, 32'h33221100, 32'hAAAAAAAA, 32'h12345678, 32'h77665544, 32'h44332211},
    '{8'h02, 1'b0, 1'b0, 32'h33221100, 32'hAAAAAAAA, 32'h12345678, 32'h77665544, 32'h55443322},
    '{8'h03, 1'b0, 1'b0, 32'h33221100, 32'hAAAAAAAA, 32'h12345678, 32'h77665544, 32'h66554433},
    '{8'h00, 1'b1, 1'b0, 32'h33221100, 32'hAAAAAAAA, 32'h12345678, 32'h77665544, 32'h77665544},
    '{8'h01, 1'b1, 1'b0, 32'h33221100, 32'hAAAAAAAA, 32'h12345678, 32'h77665544, 32'h66554433},
    '{8'h02, 1'b1, 1'b0, 32'h33221100, 32'hAAAAAAAA, 32'h12345678, 32'h77665544, 32'h55443322},
    '{8'h03, 1'b1, 1'b0, 32'h33221100, 32'hAAAAAAAA, 32'h12345678, 32'h77665544, 32'h44332211},
    '{8'hFD, 1'b0, 1'b1, 32'h55555555, 32'hDDCCBBAA, 32'h0F0E0D0C, 32'h99999999, 32'h0CDDCCBB},
    '{8'h01, 1'b1, 1'b1, 32'h55555555, 32'hDDCCBBAA, 32'h0F0E0D0C, 32'h99999999, 32'h0E0D0CDD},
    '{8'h07, 1'b1, 1'b1, 32'h55555555, 32'hDDCCBBAA, 32'h0F0E0D0C, 32'h99999999, 32'h0CDDCCBB}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0, align = 1'b0, sel = 1'b0, be = 1'b0, wr = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] res;
  logic        res_valid;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytealign_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .align_i(align),
    .src_sel_i(sel), .big_endian_i(be), .op_a_i(op_a), .op_b_i(op_b),
    .idx_wr_i(wr), .idx_wdata_i(wdata), .idx_rdata_o(rdata),
    .res_o(res), .res_valid_o(res_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with strobes cleared
  task automatic drive(input logic v, input logic al, input logic s, input logic e,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic w, input logic [7:0] wd);
    valid = v; align = al; sel = s; be = e; op_a = a; op_b = b; wr = w; wdata = wd;
    @(negedge clk);
    valid = 1'b0; align = 1'b0; wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 8'hFF);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset res", res, 32'h0);
    check("R1 reset valid", {31'h0, res_valid}, 32'h0);
    check("R1 reset rdata", {24'h0, rdata}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: temp zero after reset, LE offset 0 returns temp
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h01020304, 32'h0A0B0C0D, 1'b0, 8'h00);
    check("R1 temp zero", res, 32'h0);
    check("R8 strobe", {31'h0, res_valid}, 32'h1);

    // R5: non-align op loads temp; R8: result holds
    drive(1'b1, 1'b0, 1'b0, 1'b0, 32'hCAFEF00D, 32'h11111111, 1'b0, 8'h00);
    check("R8 hold res", res, 32'h0);
    check("R8 no strobe", {31'h0, res_valid}, 32'h0);
    idle(3);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h22222222, 32'h33333333, 1'b0, 8'h00);
    check("R5 temp from non-align, held while idle", res, 32'hCAFEF00D);

    // table walk: R2 R3 R4 R9
    foreach (VECS[i]) begin
      drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, VECS[i].idx);
      idle(3);
      check("R7 readback", {24'h0, rdata}, {24'h0, VECS[i].idx});
      drive(1'b1, 1'b0, VECS[i].sel, 1'b0, VECS[i].ap, VECS[i].bp, 1'b0, 8'h00);
      drive(1'b1, 1'b1, VECS[i].sel, VECS[i].be, VECS[i].a, VECS[i].b, 1'b0, 8'h00);
      check(VECS[i].sel ? "R2 R9 sel1 align" : (VECS[i].be ? "R4 big-endian" : "R3 little-endian"),
            res, VECS[i].exp);
    end

    // R6 / R7 timing of an index write
    drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 8'h00);
    idle(3);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 32'h33221100, 32'h77665544, 1'b1, 8'h02);
    check("R7 old value one cycle", {24'h0, rdata}, 32'h0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h33221100, 32'h77665544, 1'b0, 8'h00);
    check("R7 new value", {24'h0, rdata}, 32'h2);
    check("R6 k+1 old offset", res, 32'h33221100);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h33221100, 32'h77665544, 1'b0, 8'h00);
    check("R6 k+2 old offset", res, 32'h33221100);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h33221100, 32'h77665544, 1'b0, 8'h00);
    check("R6 k+3 new offset", res, 32'h55443322);

    summary();
    $finish;
  end
endmodule